// File: doc/BRIEF.md
# Coherent BPSK Correlation Demodulator

This block recovers binary data from a phase-shift-keyed carrier when the receiver already holds a phase-aligned copy of the carrier. Each accepted beat carries one offset-binary ADC sample and one offset-binary reference carrier sample. The block builds a 180-degree copy of the reference and turns all three values into sign and magnitude. It multiplies the ADC magnitude by each reference magnitude and attaches a sign to each product. The two signed products are summed in two separate two's-complement accumulators over one bit period. At the end of the period the block makes a hard decision by comparing the two sums.

Samples enter on a valid/ready stream. `in_ready` is low while reset is held and from the first edge after release it stays high, so the block never applies back-pressure. A beat is taken on a rising edge where both `in_valid` and `in_ready` are high. Beats with `in_valid` low are skipped and do not count toward the bit period. The decision leaves on a plain strobe with no ready. The consumer must take `out_bit` in the cycle that `out_valid` is high; the value then stays on `out_bit` until the next decision.

Top module: `bpsk_corr_demod`

## Requirements
- R1: An offset-binary code at or above 0x1FFF (for the default 14-bit width) is positive with magnitude code−0x1FFF. A code below it is negative with magnitude 0x1FFF−code. 0x1FFF is zero. Valid codes are 0x0000 to 0x3FFE.
- R2: The antiphase reference code is 0x3FFE minus the reference code. It therefore carries the same magnitude as the reference with the opposite sign.
- R3: Each product has the magnitude of its two operand magnitudes multiplied together and the XOR of their signs. A zero magnitude gives a zero term whatever its sign.
- R4: Accumulator 1 sums the ADC×reference terms and accumulator 2 sums the ADC×antiphase terms over BIT_LEN accepted samples. Full-scale inputs held for a whole period do not overflow either sum.
- R5: The decision bit is 1 only when accumulator 1 is strictly greater than accumulator 2. It is 0 when accumulator 1 is smaller and also when the two are equal.
- R6: At a period boundary both sums restart from the first product of the new period. Every accepted sample counts in exactly one period, with nothing carried over and nothing dropped.
- R7: `out_valid` is high for exactly one cycle. It rises two clock edges after the edge that accepts the last sample of a period. `out_bit` keeps its value between strobes.
- R8: After reset the first decision comes only after BIT_LEN samples have been accepted. There is no strobe before that.
- R9: `in_ready` is low while `rst` is high and high from the first edge after release. A cycle with `in_valid` low does not move the period count and does not change either sum.
- R10: The synchronous active-high reset clears the period count, both sums, `out_bit` and `out_valid`, and it discards samples still in the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample beat present |
| in_ready | output | 1 | Block accepts beats (high outside reset) |
| in_adc | input | DATA_W | Offset-binary received sample |
| in_ref | input | DATA_W | Offset-binary phase-aligned carrier sample |
| out_valid | output | 1 | One-cycle strobe for a new decision |
| out_bit | output | 1 | Demodulated bit, held between strobes |

## Verification
Each accepted beat passes through an input register and then a product register before the accumulate-and-decide edge. A decision therefore appears two edges after the edge that accepts the last sample of its period. The bench records the cycle number of each accepted beat and of each strobe and requires exactly that gap of two. It samples all outputs on the falling edge, halfway between the register updates. `in_ready` is checked one edge after reset release. The absence of a strobe during the first period is checked after the pipeline has had time to drain.

// File: rtl/bpsk_demod_pkg.sv
package bpsk_demod_pkg;
  // Sign of a sign/magnitude value.
  typedef enum logic {
    SGN_POS = 1'b0,
    SGN_NEG = 1'b1
  } sgn_e;
endpackage

// File: rtl/bpsk_sm_conv.sv
// Offset-binary code to sign and magnitude around the midscale code.
module bpsk_sm_conv
  import bpsk_demod_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic [DATA_W-1:0] code_i,
  output sgn_e              sign_o,
  output logic [DATA_W-1:0] mag_o
);
  localparam logic [DATA_W-1:0] MID = {1'b0, {(DATA_W-1){1'b1}}};

  always_comb begin
    if (code_i >= MID) begin
      sign_o = SGN_POS;
      mag_o  = code_i - MID;
    end else begin
      sign_o = SGN_NEG;
      mag_o  = MID - code_i;
    end
  end

  // A negative code always lies strictly below midscale.
  always_comb begin
    p_neg_nonzero_r1: assert (!(sign_o == SGN_NEG) || (mag_o != '0))
      else $error("negative sign with zero magnitude");
  end
endmodule

// File: rtl/bpsk_sign_mult.sv
// Magnitude product with XOR sign, returned in two's complement.
module bpsk_sign_mult
  import bpsk_demod_pkg::*;
#(
  parameter int DATA_W = 14,
  localparam int PROD_W = 2 * DATA_W + 1
) (
  input  sgn_e                     a_sign_i,
  input  logic [DATA_W-1:0]        a_mag_i,
  input  sgn_e                     b_sign_i,
  input  logic [DATA_W-1:0]        b_mag_i,
  output logic signed [PROD_W-1:0] prod_o
);
  logic [2*DATA_W-1:0]        mag_prod;
  logic signed [PROD_W-1:0]   mag_ext;
  logic                       neg;

  always_comb begin
    mag_prod = a_mag_i * b_mag_i;
    mag_ext  = $signed({1'b0, mag_prod});
    neg      = (a_sign_i != b_sign_i);
    prod_o   = neg ? -mag_ext : mag_ext;
  end

  always_comb begin
    p_zero_term_r3: assert (!((a_mag_i == '0) || (b_mag_i == '0)) || (prod_o == '0))
      else $error("zero operand gave nonzero term");
    p_term_sign_r3: assert ((mag_prod == '0) || (prod_o[PROD_W-1] == (a_sign_i != b_sign_i)))
      else $error("term sign differs from operand sign XOR");
  end
endmodule

// File: rtl/bpsk_period_ctr.sv
// Counts accepted samples over one bit period and wraps.
module bpsk_period_ctr #(
  parameter int BIT_LEN = 100000,
  localparam int CNT_W = (BIT_LEN > 2) ? $clog2(BIT_LEN) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  output logic at_last_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_LEN - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (step_i) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign at_last_o = (cnt == LAST);

  p_cnt_range_r8: assert property (@(posedge clk) disable iff (rst) cnt <= LAST)
    else $error("period count out of range");
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst) !step_i |=> $stable(cnt))
    else $error("period count moved without an accepted sample");
endmodule

// File: rtl/bpsk_corr_acc.sv
// One correlation accumulator; restarts from the current term on the first sample of a period.
module bpsk_corr_acc #(
  parameter int PROD_W = 29,
  parameter int ACC_W  = 47
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en_i,
  input  logic                     first_i,
  input  logic signed [PROD_W-1:0] term_i,
  output logic signed [ACC_W-1:0]  total_o
);
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] term_x;

  always_comb begin
    term_x  = ACC_W'(term_i);
    total_o = (first_i ? '0 : acc) + term_x;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (en_i) begin
      acc <= total_o;
    end
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
      (en_i && !first_i && (acc[ACC_W-1] == term_x[ACC_W-1])) |-> (total_o[ACC_W-1] == acc[ACC_W-1]))
    else $error("accumulator wrapped");
endmodule

// File: rtl/bpsk_corr_demod.sv
// Coherent BPSK correlation demodulator: input register, product register, accumulate/decide.
module bpsk_corr_demod
  import bpsk_demod_pkg::*;
#(
  parameter int DATA_W  = 14,
  parameter int BIT_LEN = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_adc,
  input  logic [DATA_W-1:0] in_ref,
  output logic              out_valid,
  output logic              out_bit
);
  localparam int PROD_W = 2 * DATA_W + 1;
  localparam int ACC_W  = PROD_W + $clog2(BIT_LEN + 1);
  localparam int NBR    = 2;  // branch 0: reference, branch 1: antiphase
  localparam logic [DATA_W-1:0] FULL = {{(DATA_W-1){1'b1}}, 1'b0};

  logic accept;
  logic at_last;
  logic in_ready_q;

  // Stage 1: registered raw codes.
  logic              s1_valid, s1_last;
  logic [DATA_W-1:0] s1_adc;
  logic [DATA_W-1:0] s1_ref [NBR];

  // Stage 2: registered signed terms.
  logic                     s2_valid, s2_last;
  logic signed [PROD_W-1:0] s2_term [NBR];

  // Accumulate stage.
  logic                     first_q;
  logic signed [PROD_W-1:0] term_w  [NBR];
  logic signed [ACC_W-1:0]  total_w [NBR];
  logic [DATA_W-1:0]        ref_mag [NBR];
  sgn_e                     ref_sgn [NBR];
  logic [DATA_W-1:0]        adc_mag;
  sgn_e                     adc_sgn;

  assign in_ready = in_ready_q;
  assign accept   = in_valid && in_ready_q;

  always_ff @(posedge clk) begin
    if (rst) in_ready_q <= 1'b0;
    else     in_ready_q <= 1'b1;
  end

  bpsk_period_ctr #(.BIT_LEN(BIT_LEN)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .step_i   (accept),
    .at_last_o(at_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_last   <= 1'b0;
      s1_adc    <= '0;
      s1_ref[0] <= '0;
      s1_ref[1] <= '0;
    end else begin
      s1_valid <= accept;
      s1_last  <= accept && at_last;
      if (accept) begin
        s1_adc    <= in_adc;
        s1_ref[0] <= in_ref;
        s1_ref[1] <= FULL - in_ref;
      end
    end
  end

  bpsk_sm_conv #(.DATA_W(DATA_W)) u_conv_adc (
    .code_i(s1_adc),
    .sign_o(adc_sgn),
    .mag_o (adc_mag)
  );

  for (genvar g = 0; g < NBR; g++) begin : g_branch
    bpsk_sm_conv #(.DATA_W(DATA_W)) u_conv (
      .code_i(s1_ref[g]),
      .sign_o(ref_sgn[g]),
      .mag_o (ref_mag[g])
    );

    bpsk_sign_mult #(.DATA_W(DATA_W)) u_mult (
      .a_sign_i(adc_sgn),
      .a_mag_i (adc_mag),
      .b_sign_i(ref_sgn[g]),
      .b_mag_i (ref_mag[g]),
      .prod_o  (term_w[g])
    );

    bpsk_corr_acc #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
      .clk    (clk),
      .rst    (rst),
      .en_i   (s2_valid),
      .first_i(first_q),
      .term_i (s2_term[g]),
      .total_o(total_w[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_last  <= 1'b0;
      for (int i = 0; i < NBR; i++) s2_term[i] <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_last  <= s1_last;
      if (s1_valid) begin
        for (int i = 0; i < NBR; i++) s2_term[i] <= term_w[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q   <= 1'b1;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= s2_valid && s2_last;
      if (s2_valid) first_q <= s2_last;
      if (s2_valid && s2_last) out_bit <= (total_w[0] > total_w[1]);
    end
  end

  p_ready_in_reset_r9: assert property (@(posedge clk) rst |=> !in_ready)
    else $error("ready high during reset");
  p_ready_after_reset_r9: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> in_ready)
    else $error("ready low outside reset");
  p_one_shot_r7: assert property (@(posedge clk) disable iff (rst) out_valid |=> !out_valid)
    else $error("strobe longer than one cycle");
  p_strobe_cause_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid) |-> $past(s2_valid && s2_last))
    else $error("strobe without a completed period");
  p_bit_hold_r7: assert property (@(posedge clk) disable iff (rst) !out_valid |-> $stable(out_bit))
    else $error("decision changed between strobes");
endmodule

// File: tb/bpsk_corr_demod_tb_top.sv
`timescale 1ns/1ps
module bpsk_corr_demod_tb_top;
  localparam int DW   = 14;
  localparam int BL   = 8;
  localparam int MIDV = 8191;
  localparam int FULV = 16382;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_adc = '0;
  logic [DW-1:0] in_ref = '0;
  logic          out_valid;
  logic          out_bit;

  always #4 clk = ~clk;

  bpsk_corr_demod #(.DATA_W(DW), .BIT_LEN(BL)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_adc   (in_adc),
    .in_ref   (in_ref),
    .out_valid(out_valid),
    .out_bit  (out_bit)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cyc      = 0;
  bit    done     = 1'b0;

  // Bench model of the expected decisions.
  longint model_sum = 0;
  int     model_cnt = 0;
  int     n_exp     = 0;
  int     rd_idx    = 0;
  bit     exp_bit [64];
  int     end_cyc [64];

  // Recorded strobes.
  int n_rec     = 0;
  bit rec_bit  [64];
  int rec_cyc  [64];
  int n_double  = 0;
  bit prev_v    = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (out_valid && n_rec < 64) begin
      rec_bit[n_rec] = out_bit;
      rec_cyc[n_rec] = cyc;
      n_rec = n_rec + 1;
    end
    if (out_valid && prev_v) n_double = n_double + 1;
    prev_v = out_valid;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int wave(input int i);
    case (i % 8)
      0: return MIDV + 3000;
      1: return MIDV + 6000;
      2: return MIDV + 3000;
      3: return MIDV;
      4: return MIDV - 3000;
      5: return MIDV - 6000;
      6: return MIDV - 3000;
      default: return MIDV;
    endcase
  endfunction

  task automatic send(input int adc, input int rf);
    bit rdy;
    @(negedge clk);
    in_valid = 1'b1;
    in_adc   = DW'(adc);
    in_ref   = DW'(rf);
    rdy      = in_ready;
    @(posedge clk);
    #1;
    if (rdy) begin
      model_sum += longint'(adc - MIDV) * longint'(rf - MIDV);
      model_cnt++;
      if (model_cnt == BL) begin
        exp_bit[n_exp] = (model_sum > 0);
        end_cyc[n_exp] = cyc;
        n_exp++;
        model_sum = 0;
        model_cnt = 0;
      end
    end
  endtask

  task automatic idle(input int n, input int adc, input int rf);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_adc   = DW'(adc);
      in_ref   = DW'(rf);
    end
  endtask

  task automatic drain(input string req);
    for (int idx = rd_idx; idx < n_exp; idx++) begin
      int w;
      w = 0;
      while (n_rec <= idx && w < 64) begin
        @(posedge clk);
        #2;
        w++;
      end
      check(n_rec > idx, {req, " R7 strobe present"}, n_rec, idx + 1);
      if (n_rec > idx) begin
        check(rec_bit[idx] == exp_bit[idx], req, rec_bit[idx], exp_bit[idx]);
        check(rec_cyc[idx] == end_cyc[idx] + 2, "R7 latency", rec_cyc[idx] - end_cyc[idx], 2);
      end
    end
    rd_idx = n_exp;
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_sum = 0;
    model_cnt = 0;
    n_exp  = n_rec;
    rd_idx = n_rec;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    @(negedge clk);
    check(in_ready == 1'b0, "R9 ready low in reset", in_ready, 0);
    check(out_valid == 1'b0, "R10 out_valid cleared", out_valid, 0);
    check(out_bit == 1'b0, "R10 out_bit cleared", out_bit, 0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R9 ready after release", in_ready, 1);
  endtask

  task automatic t_first_period();
    int base;
    base = n_rec;
    for (int i = 0; i < BL - 1; i++) send(wave(i), wave(i));
    idle(6, MIDV, MIDV);
    check(n_rec == base, "R8 no strobe before a full period", n_rec - base, 0);
    send(wave(BL - 1), wave(BL - 1));
    idle(1, MIDV, MIDV);
    drain("R8 first decision after BIT_LEN samples");
  endtask

  task automatic t_phase();
    for (int i = 0; i < BL; i++) send(wave(i), wave(i));
    for (int i = 0; i < BL; i++) send(FULV - wave(i), wave(i));
    idle(1, MIDV, MIDV);
    drain("R2/R5 in-phase then antiphase decisions");
    idle(3, MIDV, MIDV);
    check(out_bit == 1'b0 && out_valid == 1'b0, "R7 bit held after strobe", out_bit, 0);
  endtask

  task automatic t_tie();
    for (int i = 0; i < BL; i++) send(MIDV, wave(i));
    for (int i = 0; i < BL; i++) send(wave(i), MIDV);
    idle(1, MIDV, MIDV);
    drain("R5/R1/R3 zero correlation decides 0");
  endtask

  task automatic t_full_scale();
    for (int i = 0; i < BL; i++) send(0, 0);
    for (int i = 0; i < BL; i++) send(FULV, 0);
    for (int i = 0; i < BL; i++) send(FULV, FULV);
    idle(1, MIDV, MIDV);
    drain("R4 full-scale sums");
  endtask

  task automatic t_boundary();
    for (int i = 0; i < BL - 1; i++) send(MIDV + 1, MIDV - 1);
    send(FULV, FULV);
    send(0, MIDV + 100);
    for (int i = 1; i < BL; i++) send(MIDV + 1, MIDV + 1);
    idle(1, MIDV, MIDV);
    drain("R6 restart at period boundary");
  endtask

  task automatic t_gaps();
    for (int i = 0; i < BL; i++) begin
      send(wave(i), wave(i));
      if (i % 3 == 1) idle(2, 0, FULV);
    end
    idle(1, MIDV, MIDV);
    drain("R9 invalid cycles ignored");
  endtask

  task automatic t_reset_mid();
    for (int i = 0; i < 3; i++) send(FULV, FULV);
    do_reset();
    @(negedge clk);
    for (int i = 0; i < BL - 1; i++) send(MIDV + 1, MIDV - 1);
    send(MIDV - 1, MIDV);
    idle(1, MIDV, MIDV);
    drain("R10 reset discards partial period");
  endtask

  initial begin
    t_reset_state();
    t_first_period();
    t_phase();
    t_tie();
    t_full_scale();
    t_boundary();
    t_gaps();
    t_reset_mid();
    idle(4, MIDV, MIDV);
    check(n_double == 0, "R7 strobe width one cycle", n_double, 0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule